// File: doc/BRIEF.md
# Satellite Tuner Control Register File

This block is the device-side register file of a satellite tuner front end. Configuration arrives as write transactions: a stream of bytes framed by a start pulse and a stop pulse. No separate address byte is used. The high-order bits of the first byte in a transaction choose one of six register pairs, through a prefix whose length varies. That first byte, prefix bits included, lands in the lower register of the pair. The second byte lands in the upper register. Any later bytes in the same transaction are dropped.

A read request returns one status byte. It carries a power-on-reset flag, which stays set until the first write transaction that contains data completes. It also carries a lock flag that follows an external lock input. All twelve registers drive downstream logic in parallel. Two decoded views are also provided: the 15-bit synthesizer divider and the power-down control.

The byte input is a valid/ready stream that never applies back-pressure: `in_ready` is held high and a byte transfers on any cycle with `in_valid` high. The status output is a valid/ready stream. Once `st_valid` rises, it and `st_data` hold steady until a cycle with `st_ready` high. `st_valid` then drops on the next edge.

Top module: `tuner_regfile`

## Requirements
- R1: After reset the register bus holds, for registers 2 through 13 in order, 0x00, 0x00, 0x80, 0x00, 0xC0, 0x20, 0xDB, 0x30, 0xE1, 0xF5, 0xF0, 0x28. Register k sits at `reg_bus[(k-2)*8 +: 8]`.
- R2: The first byte of a transaction picks the pair by prefix and is stored whole in the pair's lower register. The prefixes are:
  - bit 7 = 0 selects registers 2/3;
  - bits 7:6 = 10 select 4/5;
  - bits 7:4 = 1100 select 6/7;
  - 1101 selects 8/9;
  - 1110 selects 10/11;
  - 1111 selects 12/13.
- R3: The second byte of a transaction is stored in the upper register of the pair chosen by the first byte.
- R4: A transaction carrying a single byte updates only the lower register and leaves the upper register unchanged. For example, the lone byte 0xC8 sets register 6 to 0xC8.
- R5: The third and later bytes of a transaction change no register.
- R6: A byte that arrives outside a transaction changes no register. Outside a transaction means before any start pulse, or after a stop pulse and before the next start pulse.
- R7: A read request produces one status byte. Bit 7 is the power-on-reset flag, bit 6 is the lock flag, and bits 5:0 are zero. `st_valid` and `st_data` hold until `st_ready` is seen.
- R8: The power-on-reset flag is 1 after reset. It clears when a stop pulse ends a transaction that carried at least one byte. A transaction with no bytes leaves the flag set.
- R9: The lock flag equals `lock_in` as sampled on the previous clock edge.
- R10: `div_n` equals register 2 bits 6:0 followed by register 3. `pwr_down` equals register 13 bit 7, so the transaction 0xF0, 0x80 asserts it.
- R11: `in_ready` is always high; the byte input never back-pressures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse opening a write transaction |
| frame_stop | input | 1 | Pulse closing a write transaction |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready (constant high) |
| in_data | input | 8 | Byte stream data |
| rd_req | input | 1 | Pulse requesting a status read |
| st_valid | output | 1 | Status byte valid |
| st_ready | input | 1 | Status byte accepted |
| st_data | output | 8 | Status byte |
| lock_in | input | 1 | External frequency/phase lock indication |
| reg_bus | output | 96 | Registers 2..13, register 2 in the low byte |
| div_n | output | 15 | Synthesizer divider from registers 2 and 3 |
| pwr_down | output | 1 | Power-down control, register 13 bit 7 |

## Verification
The bench sends one two-byte transaction for every prefix, using mixed bit patterns. This separates the six pair selections and shows that the prefix bits are stored in the lower register. A lone 0xC8 byte tests the one-byte case against the two-byte case. A four-byte transaction shows that writing stops after the second byte. Bytes sent without framing show that they are ignored. Status reads are taken before any write, after an empty transaction, after a real one, and with the lock input toggled, so the two flags are checked independently. A final 0xF0, 0x80 transaction exercises the power-down view.

// File: rtl/tuner_regs_pkg.sv
package tuner_regs_pkg;
  localparam int DATA_W = 8;
  localparam int NPAIR  = 6;
  localparam int NREG   = 2 * NPAIR;
  localparam int PAIR_W = $clog2(NPAIR);

  // Reset image, index 0 is register 2.
  function automatic logic [DATA_W-1:0] reg_reset(input int idx);
    case (idx)
      2:       return 8'h80;
      4:       return 8'hC0;
      5:       return 8'h20;
      6:       return 8'hDB;
      7:       return 8'h30;
      8:       return 8'hE1;
      9:       return 8'hF5;
      10:      return 8'hF0;
      11:      return 8'h28;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tnr_prefix_dec.sv
module tnr_prefix_dec
  import tuner_regs_pkg::*;
(
  input  logic [DATA_W-1:0] lead,
  output logic [PAIR_W-1:0] pair
);
  always_comb begin
    if (!lead[7])      pair = PAIR_W'(0);
    else if (!lead[6]) pair = PAIR_W'(1);
    else               pair = PAIR_W'(2) + PAIR_W'(lead[5:4]);
  end
endmodule

// File: rtl/tnr_wr_seq.sv
module tnr_wr_seq
  import tuner_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_stop,
  input  logic              byte_fire,
  input  logic [DATA_W-1:0] byte_data,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic [PAIR_W-1:0] wr_pair,
  output logic              txn_done,
  output logic              active,
  output logic [1:0]        cnt
);
  logic [PAIR_W-1:0] dec_pair, pair_q;
  logic              eff_active, fire;
  logic [1:0]        eff_cnt;

  tnr_prefix_dec u_dec (.lead(byte_data), .pair(dec_pair));

  always_comb begin
    eff_active = frame_start | active;
    eff_cnt    = frame_start ? 2'd0 : cnt;
    fire       = byte_fire & eff_active;
    wr_lo      = fire && (eff_cnt == 2'd0);
    wr_hi      = fire && (eff_cnt == 2'd1);
    wr_pair    = wr_lo ? dec_pair : pair_q;
    txn_done   = frame_stop && eff_active && ((eff_cnt != 2'd0) || fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= 2'd0;
      pair_q <= '0;
    end else begin
      if (frame_stop)       active <= 1'b0;
      else if (frame_start) active <= 1'b1;
      if (frame_start)
        cnt <= fire ? 2'd1 : 2'd0;
      else if (fire && cnt != 2'd2)
        cnt <= cnt + 2'd1;
      if (wr_lo) pair_q <= dec_pair;
    end
  end
endmodule

// File: rtl/tnr_reg_bank.sv
module tnr_reg_bank
  import tuner_regs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic [PAIR_W-1:0]      wr_pair,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] regs
);
  logic [PAIR_W:0] lo_idx, hi_idx;
  assign lo_idx = {wr_pair, 1'b0};
  assign hi_idx = {wr_pair, 1'b1};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [PAIR_W:0] IDX = (PAIR_W+1)'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i*DATA_W +: DATA_W] <= reg_reset(i);
      else if ((wr_lo && lo_idx == IDX) || (wr_hi && hi_idx == IDX))
        regs[i*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/tnr_status.sv
module tnr_status
  import tuner_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_done,
  input  logic              lock_in,
  input  logic              rd_req,
  input  logic              st_ready,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              por,
  output logic              lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      por      <= 1'b1;
      lock_q   <= 1'b0;
      st_valid <= 1'b0;
      st_data  <= '0;
    end else begin
      lock_q <= lock_in;
      if (txn_done) por <= 1'b0;
      if (st_valid) begin
        if (st_ready) st_valid <= 1'b0;
      end else if (rd_req) begin
        st_valid <= 1'b1;
        st_data  <= {por, lock_q, {(DATA_W-2){1'b0}}};
      end
    end
  end
endmodule

// File: rtl/tuner_regfile.sv
module tuner_regfile
  import tuner_regs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   frame_stop,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   rd_req,
  output logic                   st_valid,
  input  logic                   st_ready,
  output logic [DATA_W-1:0]      st_data,
  input  logic                   lock_in,
  output logic [NREG*DATA_W-1:0] reg_bus,
  output logic [14:0]            div_n,
  output logic                   pwr_down
);
  logic              wr_lo, wr_hi, txn_done, seq_active, por, lock_q;
  logic [PAIR_W-1:0] wr_pair;
  logic [1:0]        seq_cnt;

  assign in_ready = 1'b1;

  tnr_wr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .byte_fire(in_valid & in_ready), .byte_data(in_data),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_pair(wr_pair), .txn_done(txn_done),
    .active(seq_active), .cnt(seq_cnt)
  );

  tnr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_pair(wr_pair), .wr_data(in_data), .regs(reg_bus)
  );

  tnr_status u_stat (
    .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .lock_in(lock_in),
    .rd_req(rd_req), .st_ready(st_ready), .st_valid(st_valid),
    .st_data(st_data), .por(por), .lock_q(lock_q)
  );

  // Divider spans register 2 bits 6:0 and register 3; power-down is reg 13 bit 7.
  assign div_n    = {reg_bus[6:0], reg_bus[15:8]};
  assign pwr_down = reg_bus[11*DATA_W + 7];
endmodule

// File: rtl/tuner_regfile_chk.sv
module tuner_regfile_chk
  import tuner_regs_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_start,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   st_valid,
  input logic                   st_ready,
  input logic [DATA_W-1:0]      st_data,
  input logic                   lock_in,
  input logic                   lock_q,
  input logic                   por,
  input logic                   seq_active,
  input logic [1:0]             seq_cnt,
  input logic [NREG*DATA_W-1:0] reg_bus
);
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data));

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lock_q == $past(lock_in));

  assert_por_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> !por);

  assert_extra_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && seq_active && seq_cnt == 2'd2 && !frame_start |=> $stable(reg_bus));

  assert_unframed_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !seq_active && !frame_start |=> $stable(reg_bus));
endmodule

bind tuner_regfile tuner_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_ready(in_ready), .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
  .lock_in(lock_in), .lock_q(lock_q), .por(por), .seq_active(seq_active),
  .seq_cnt(seq_cnt), .reg_bus(reg_bus)
);

// File: tb/tuner_regfile_test.sv
`timescale 1ns/1ps
module tuner_regfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_start = 0, frame_stop = 0, in_valid = 0, rd_req = 0, st_ready = 0, lock_in = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, st_valid, pwr_down;
  logic [7:0]  st_data;
  logic [95:0] reg_bus;
  logic [14:0] div_n;
  int checks = 0, fails = 0;
  logic [7:0] model [12];

  always #2.5 clk = ~clk;

  tuner_regfile uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .rd_req(rd_req),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .lock_in(lock_in),
    .reg_bus(reg_bus), .div_n(div_n), .pwr_down(pwr_down)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pair_of(input logic [7:0] b);
    if (!b[7]) return 0;
    if (!b[6]) return 1;
    return 2 + int'(b[5:4]);
  endfunction

  function automatic logic [95:0] model_bus();
    logic [95:0] v;
    for (int i = 0; i < 12; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); in_valid = 1; in_data = b;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic send_frame(input logic [7:0] b0, b1, b2, b3, input int n);
    logic [7:0] bs [4];
    int p;
    bs = '{b0, b1, b2, b3};
    p = 0;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(bs[i]);
      if (i == 0) begin p = pair_of(bs[0]); model[2*p] = bs[0]; end
      else if (i == 1) model[2*p+1] = bs[1];
    end
    @(negedge clk); frame_stop = 1;
    @(negedge clk); frame_stop = 0;
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    logic [7:0] first;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check({req, " valid"}, st_valid, 1'b1);
    check(req, st_data, exp);
    first = st_data;
    @(negedge clk); @(negedge clk);
    check("R7 hold", {st_valid, st_data}, {1'b1, first});
    st_ready = 1;
    @(negedge clk); st_ready = 0;
    check("R7 drop", st_valid, 1'b0);
  endtask

  task automatic t_reset();
    model = '{8'h00, 8'h00, 8'h80, 8'h00, 8'hC0, 8'h20, 8'hDB, 8'h30, 8'hE1, 8'hF5, 8'hF0, 8'h28};
    check("R1 reset image", reg_bus, model_bus());
    check("R11 ready", in_ready, 1'b1);
    check("R7 idle", st_valid, 1'b0);
    check("R10 reset pwr_down", pwr_down, 1'b0);
  endtask

  task automatic t_status_before();
    read_status("R8 por at reset", 8'h80);
    send_frame(0, 0, 0, 0, 0);
    read_status("R8 empty frame keeps por", 8'h80);
  endtask

  task automatic t_pairs();
    send_frame(8'h12, 8'h34, 0, 0, 2);
    check("R2 R3 pair 2/3", reg_bus, model_bus());
    check("R10 divider", div_n, 15'h1234);
    read_status("R8 por cleared", 8'h00);
    send_frame(8'h9A, 8'h55, 0, 0, 2);
    check("R2 R3 pair 4/5", reg_bus, model_bus());
    send_frame(8'hC4, 8'hA6, 0, 0, 2);
    check("R2 R3 pair 6/7", reg_bus, model_bus());
    send_frame(8'hD7, 8'h3C, 0, 0, 2);
    check("R2 R3 pair 8/9", reg_bus, model_bus());
    send_frame(8'hE5, 8'h81, 0, 0, 2);
    check("R2 R3 pair 10/11", reg_bus, model_bus());
    send_frame(8'hF3, 8'h7E, 0, 0, 2);
    check("R2 R3 pair 12/13", reg_bus, model_bus());
    check("R10 pwr_down low", pwr_down, 1'b0);
  endtask

  task automatic t_single();
    send_frame(8'hC8, 0, 0, 0, 1);
    check("R4 reg6", reg_bus[4*8 +: 8], 8'hC8);
    check("R4 reg7 kept", reg_bus[5*8 +: 8], 8'hA6);
    check("R4 full image", reg_bus, model_bus());
  endtask

  task automatic t_extra();
    send_frame(8'h8B, 8'h0A, 8'hFF, 8'h00, 4);
    check("R5 extra bytes ignored", reg_bus, model_bus());
  endtask

  task automatic t_unframed();
    send_byte(8'h7F); send_byte(8'h11);
    check("R6 unframed ignored", reg_bus, model_bus());
    check("R6 divider kept", div_n, 15'h1234);
  endtask

  task automatic t_lock();
    @(negedge clk); lock_in = 1;
    @(negedge clk); @(negedge clk);
    read_status("R9 lock set", 8'h40);
    @(negedge clk); lock_in = 0;
    @(negedge clk); @(negedge clk);
    read_status("R9 lock clear", 8'h00);
  endtask

  task automatic t_power_down();
    send_frame(8'hF0, 8'h80, 0, 0, 2);
    check("R10 pwr_down set", pwr_down, 1'b1);
    check("R10 image", reg_bus, model_bus());
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status_before();
    t_pairs();
    t_single();
    t_extra();
    t_unframed();
    t_lock();
    t_power_down();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule